// File: doc/BRIEF.md
# Mode-Gated System Bus Decoder

This block sits between the byte-wide port of an 8-bit CPU and the memories of a small handheld-style system. For each access it decodes the 16-bit address. It raises a one-hot select for the target memory region and gives the offset inside that region. It also chooses the byte that goes back to the CPU. The memories themselves are outside the block. They return their byte on a shared read-data input in the same cycle as the select.

The display mode decides who may reach video memory and sprite memory. A 256-byte boot image covers the bottom of the map until software turns it off. A mirror window folds back onto the two work-RAM banks. A few system registers live inside the block: the free-running divider, the line-compare register with its coincidence flag, the pending-interrupt register, the interrupt-enable register and the boot-disable control. The pending-interrupt register merges live request lines into its read value, and a write to it is passed back to the request sources.

Top module: `sysbus_decoder`

## Requirements
- R1: While the boot overlay is on (its state after reset), a read of 0x0000–0x00FF selects the boot region (select bit 0) with offset addr[7:0]. Reads of 0x0100–0x7FFF, and every write in 0x0000–0x7FFF, select cartridge ROM (select bit 1) with offset addr[14:0].
- R2: A write of a nonzero byte to 0xFF50 turns the overlay off for good, and 0x0000–0x00FF reads then go to cartridge ROM. A write of zero changes nothing. A read of 0xFF50 returns 0xFF.
- R3: Video RAM at 0x8000–0x9FFF (select bit 2, offset addr[12:0]) is reachable when disp_mode is not 3 (drawing). In mode 3 a read returns 0xFF and a write raises no select.
- R4: Cartridge RAM at 0xA000–0xBFFF uses select bit 3 with offset addr[12:0]. Work RAM bank 0 at 0xC000–0xCFFF uses select bit 4 and bank 1 at 0xD000–0xDFFF uses select bit 5, each with offset addr[11:0]. 0xE000–0xFDFF mirrors them: bit 12 of the address chooses the bank and addr[11:0] is the offset.
- R5: Sprite memory at 0xFE00–0xFE9F (select bit 6, offset addr[7:0]) is reachable only when disp_mode is 0 (horizontal blank) or 1 (vertical blank). In modes 2 and 3 a read returns 0xFF and a write raises no select.
- R6: In 0xFEA0–0xFEFF a read returns 0x00 in modes 0 and 1 and 0xFF in modes 2 and 3. No access in this range raises any select.
- R7: A 16-bit divider counts up by one each clock. A read of 0xFF04 returns its upper byte, and any write to 0xFF04 clears the whole counter.
- R8: A write to 0xFF45 loads line_cmp and sets coin_flag to (line_count == written byte). When coin_irq_en is high and the two match, stat_irq_req pulses for exactly one cycle. A read of 0xFF45 returns line_cmp.
- R9: A read of 0xFF0F returns the stored byte, with bits 0 (vertical blank), 1 (display status), 2 (timer) and 4 (joypad) replaced by irq_live. A write stores the byte and, in the same cycle, raises irq_push with irq_push_val equal to the written bits 4:0.
- R10: 0xFF80–0xFFFE selects high RAM (select bit 8, offset addr[6:0]). I/O addresses 0xFF00–0xFF7F other than 0x04, 0x0F, 0x45 and 0x50 select the external I/O port (select bit 7, offset addr[6:0]). 0xFFFF is the interrupt-enable register: it is readable and writable, and its bits 4:0 drive irq_enable.
- R11: cpu_rdata updates at the clock edge that ends a read cycle and holds its value while cpu_rd is low. It resets to 0x00.
- R12: mem_sel has at most one bit set and is all zero when no strobe is high. mem_we is high exactly when a select is raised by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 8 | CPU write byte, also passed to the memories |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_rdata | output | 8 | Registered read byte |
| disp_mode | input | 2 | 0 h-blank, 1 v-blank, 2 sprite search, 3 drawing |
| line_count | input | 8 | Current display line |
| coin_irq_en | input | 1 | Coincidence interrupt enable |
| irq_live | input | 5 | Live request lines from the interrupt sources |
| mem_rdata | input | 8 | Byte returned by the selected memory |
| mem_sel | output | 9 | One-hot region select |
| mem_loc | output | 15 | Offset inside the selected region |
| mem_we | output | 1 | Write enable for the selected region |
| line_cmp | output | 8 | Line-compare value |
| coin_flag | output | 1 | Coincidence flag |
| stat_irq_req | output | 1 | Display-status request pulse |
| irq_push | output | 1 | Pending-register write strobe to the sources |
| irq_push_val | output | 5 | Request bits pushed to the sources |
| irq_enable | output | 5 | Interrupt-enable mask |

## Verification
The bench goes after the edges of each range: 0x00FF and 0x0100 under the overlay, 0xFDFF at the far end of the mirror, 0xFE9F and 0xFEA0 on either side of the sprite area, and 0xFF7F and 0xFF80 between I/O and high RAM. An off-by-one there sends a byte to the neighbouring memory. Each access is tried in every display mode class. A decoder that treats sprite search as a blank mode lets the CPU corrupt sprite memory. One that forgets to drop writes during drawing raises a select that the video side does not expect. The bench also writes zero to the boot-disable address, which must not drop the overlay. It checks that a mismatching line-compare write raises no request. It checks that the pending-register read value shows the live lines and not stale stored bits.

// File: rtl/sysbus_pkg.sv
// Package: shared constants and types for the system bus decoder.
// Assumes a 16-bit byte address space and byte-wide data.
package sysbus_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int NREG   = 9;
    localparam int LOC_W  = 15;
    localparam int IRQ_N  = 5;
    localparam int DIV_W  = 16;
    localparam int IDX_W  = $clog2(NREG);

    localparam int RG_BOOT = 0;
    localparam int RG_CROM = 1;
    localparam int RG_VRAM = 2;
    localparam int RG_CRAM = 3;
    localparam int RG_WRM0 = 4;
    localparam int RG_WRM1 = 5;
    localparam int RG_OAM  = 6;
    localparam int RG_IO   = 7;
    localparam int RG_HRAM = 8;

    typedef enum logic [1:0] {
        SRC_EXT  = 2'd0,
        SRC_ONES = 2'd1,
        SRC_ZERO = 2'd2,
        SRC_REG  = 2'd3
    } rsrc_e;
endpackage

// File: rtl/sysbus_map.sv
// Module: combinational address map. Picks the target region, the offset
// inside it and the read-data source. Assumes the display mode encoding
// 0/1 = blank, 2 = sprite search, 3 = drawing.
module sysbus_map
    import sysbus_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [1:0]        mode,
    input  logic              boot_on,
    output logic [NREG-1:0]   sel,
    output logic [LOC_W-1:0]  loc,
    output rsrc_e             src
);
    logic             hit_v;
    logic [IDX_W-1:0] hit_i;
    logic             in_blank;
    logic             drawing;

    assign in_blank = (mode == 2'd0) || (mode == 2'd1);
    assign drawing  = (mode == 2'd3);

    // Region, offset and read source for the current address.
    always_comb begin
        hit_v = 1'b0;
        hit_i = '0;
        loc   = '0;
        src   = SRC_EXT;
        if (addr < 16'h8000) begin
            hit_v = 1'b1;
            if (rd && boot_on && addr[15:8] == 8'h00) begin
                hit_i = IDX_W'(RG_BOOT);
                loc   = LOC_W'(addr[7:0]);
            end else begin
                hit_i = IDX_W'(RG_CROM);
                loc   = addr[14:0];
            end
        end else if (addr < 16'hA000) begin
            if (drawing) src = SRC_ONES;
            else begin
                hit_v = 1'b1;
                hit_i = IDX_W'(RG_VRAM);
                loc   = LOC_W'(addr[12:0]);
            end
        end else if (addr < 16'hC000) begin
            hit_v = 1'b1;
            hit_i = IDX_W'(RG_CRAM);
            loc   = LOC_W'(addr[12:0]);
        end else if (addr < 16'hFE00) begin
            hit_v = 1'b1;
            hit_i = addr[12] ? IDX_W'(RG_WRM1) : IDX_W'(RG_WRM0);
            loc   = LOC_W'(addr[11:0]);
        end else if (addr < 16'hFEA0) begin
            if (in_blank) begin
                hit_v = 1'b1;
                hit_i = IDX_W'(RG_OAM);
                loc   = LOC_W'(addr[7:0]);
            end else src = SRC_ONES;
        end else if (addr < 16'hFF00) begin
            src = in_blank ? SRC_ZERO : SRC_ONES;
        end else if (addr < 16'hFF80) begin
            case (addr[6:0])
                7'h04, 7'h0F, 7'h45: src = SRC_REG;
                7'h50:               src = SRC_ONES;
                default: begin
                    hit_v = 1'b1;
                    hit_i = IDX_W'(RG_IO);
                    loc   = LOC_W'(addr[6:0]);
                end
            endcase
        end else if (addr != 16'hFFFF) begin
            hit_v = 1'b1;
            hit_i = IDX_W'(RG_HRAM);
            loc   = LOC_W'(addr[6:0]);
        end else begin
            src = SRC_REG;
        end
    end

    // One select line per region, raised only while a strobe is high.
    for (genvar g = 0; g < NREG; g++) begin : g_sel
        assign sel[g] = hit_v && (hit_i == IDX_W'(g)) && (rd || wr);
    end
endmodule

// File: rtl/sysbus_regs.sv
// Module: system registers owned by the decoder: divider, line compare,
// pending and enable interrupt registers, boot overlay control.
// Assumes writes last one cycle per strobe.
module sysbus_regs
    import sysbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr,
    input  logic [7:0]        line_count,
    input  logic              coin_irq_en,
    input  logic [IRQ_N-1:0]  irq_live,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              boot_on,
    output logic [7:0]        line_cmp,
    output logic              coin_flag,
    output logic              stat_irq_req,
    output logic              irq_push,
    output logic [IRQ_N-1:0]  irq_push_val,
    output logic [IRQ_N-1:0]  irq_enable
);
    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] pend_q;
    logic [DATA_W-1:0] ie_q;
    logic wr_div, wr_cmp, wr_pend, wr_boot, wr_ie;

    assign wr_div  = wr && addr == 16'hFF04;
    assign wr_pend = wr && addr == 16'hFF0F;
    assign wr_cmp  = wr && addr == 16'hFF45;
    assign wr_boot = wr && addr == 16'hFF50;
    assign wr_ie   = wr && addr == 16'hFFFF;

    // Free-running divider, cleared by any write to its address.
    always_ff @(posedge clk) begin
        if (!rst_n || wr_div) div_q <= '0;
        else                  div_q <= div_q + 1'b1;
    end

    // Boot overlay flag: one-way switch off on a nonzero write.
    always_ff @(posedge clk) begin
        if (!rst_n)                        boot_on <= 1'b1;
        else if (wr_boot && wdata != '0)   boot_on <= 1'b0;
    end

    // Line compare register, coincidence flag and request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_cmp     <= '0;
            coin_flag    <= 1'b0;
            stat_irq_req <= 1'b0;
        end else begin
            stat_irq_req <= wr_cmp && coin_irq_en && (line_count == wdata);
            if (wr_cmp) begin
                line_cmp  <= wdata;
                coin_flag <= (line_count == wdata);
            end
        end
    end

    // Stored pending flags and interrupt enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            ie_q   <= '0;
        end else begin
            if (wr_pend) pend_q <= wdata;
            if (wr_ie)   ie_q   <= wdata;
        end
    end

    assign irq_push     = wr_pend;
    assign irq_push_val = wdata[IRQ_N-1:0];
    assign irq_enable   = ie_q[IRQ_N-1:0];

    // Read value of the owned register at the current address.
    always_comb begin
        case (addr)
            16'hFF04: reg_rdata = div_q[DIV_W-1 -: DATA_W];
            16'hFF0F: reg_rdata = {pend_q[7:5], irq_live[4], pend_q[3], irq_live[2:0]};
            16'hFF45: reg_rdata = line_cmp;
            16'hFFFF: reg_rdata = ie_q;
            default:  reg_rdata = 8'hFF;
        endcase
    end
endmodule

// File: rtl/sysbus_rdata.sv
// Module: read-data register. Captures the steered byte on each read and
// holds it otherwise.
module sysbus_rdata
    import sysbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  rsrc_e             src,
    input  logic [DATA_W-1:0] ext_data,
    input  logic [DATA_W-1:0] reg_data,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] pick;

    // Choose the byte for the current read source.
    always_comb begin
        case (src)
            SRC_ONES: pick = '1;
            SRC_ZERO: pick = '0;
            SRC_REG:  pick = reg_data;
            default:  pick = ext_data;
        endcase
    end

    // Register the byte at the edge that ends a read.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= pick;
    end
endmodule

// File: rtl/sysbus_decoder.sv
// Top: system bus decoder. Joins the address map, the owned registers and
// the read-data register. Memories answer combinationally on mem_rdata.
module sysbus_decoder
    import sysbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic [1:0]        disp_mode,
    input  logic [7:0]        line_count,
    input  logic              coin_irq_en,
    input  logic [IRQ_N-1:0]  irq_live,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [NREG-1:0]   mem_sel,
    output logic [LOC_W-1:0]  mem_loc,
    output logic              mem_we,
    output logic [7:0]        line_cmp,
    output logic              coin_flag,
    output logic              stat_irq_req,
    output logic              irq_push,
    output logic [IRQ_N-1:0]  irq_push_val,
    output logic [IRQ_N-1:0]  irq_enable
);
    logic              boot_on;
    rsrc_e             src;
    logic [DATA_W-1:0] reg_rdata;

    sysbus_map u_map (
        .addr(cpu_addr), .rd(cpu_rd), .wr(cpu_wr), .mode(disp_mode),
        .boot_on(boot_on), .sel(mem_sel), .loc(mem_loc), .src(src)
    );

    sysbus_regs u_regs (
        .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .wdata(cpu_wdata),
        .wr(cpu_wr), .line_count(line_count), .coin_irq_en(coin_irq_en),
        .irq_live(irq_live), .reg_rdata(reg_rdata), .boot_on(boot_on),
        .line_cmp(line_cmp), .coin_flag(coin_flag),
        .stat_irq_req(stat_irq_req), .irq_push(irq_push),
        .irq_push_val(irq_push_val), .irq_enable(irq_enable)
    );

    sysbus_rdata u_rdata (
        .clk(clk), .rst_n(rst_n), .rd(cpu_rd), .src(src),
        .ext_data(mem_rdata), .reg_data(reg_rdata), .rdata(cpu_rdata)
    );

    assign mem_we = cpu_wr && (mem_sel != '0);
endmodule

// File: rtl/sysbus_decoder_chk.sv
// Checker: temporal properties of the decoder, bound to the top module.
module sysbus_decoder_chk
    import sysbus_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic [1:0]        disp_mode,
    input logic [NREG-1:0]   mem_sel,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              coin_flag,
    input logic              stat_irq_req,
    input logic              boot_on
);
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_sel)); // R12
    AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rd && !cpu_wr) |-> (mem_sel == '0)); // R12
    AST_VRAM_DRAW_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_mode == 2'd3 && cpu_addr >= 16'h8000 && cpu_addr < 16'hA000)
        |-> !mem_sel[RG_VRAM]); // R3
    AST_OAM_BLANK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel[RG_OAM] |-> (disp_mode == 2'd0 || disp_mode == 2'd1)); // R5
    AST_BOOT_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_on |=> !boot_on); // R2
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |=> $stable(cpu_rdata)); // R11
    AST_STAT_NEEDS_COIN: assert property (@(posedge clk) disable iff (!rst_n)
        stat_irq_req |-> coin_flag); // R8
endmodule

bind sysbus_decoder sysbus_decoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .disp_mode(disp_mode), .mem_sel(mem_sel),
    .cpu_rdata(cpu_rdata), .coin_flag(coin_flag),
    .stat_irq_req(stat_irq_req), .boot_on(boot_on)
);

// File: tb/tb_sysbus_decoder.sv
// Bench: table of read vectors plus directed tests for the decoder.
module tb_sysbus_decoder;
    localparam int CLK_NS = 10;
    localparam int NV = 22;
    // {addr, mode, region (15 = fixed value), offset, expected byte}
    localparam logic [44:0] VEC [NV] = '{
        {16'h0042, 2'd0, 4'd1,  15'h0042, 8'h53},
        {16'h4ABC, 2'd3, 4'd1,  15'h4ABC, 8'hCD},
        {16'h8123, 2'd0, 4'd2,  15'h0123, 8'h45},
        {16'h8123, 2'd3, 4'd15, 15'h0000, 8'hFF},
        {16'h8123, 2'd2, 4'd2,  15'h0123, 8'h45},
        {16'hA010, 2'd3, 4'd3,  15'h0010, 8'h43},
        {16'hC345, 2'd0, 4'd4,  15'h0345, 8'h89},
        {16'hD678, 2'd0, 4'd5,  15'h0678, 8'hCD},
        {16'hE345, 2'd1, 4'd4,  15'h0345, 8'h89},
        {16'hFDFF, 2'd0, 4'd5,  15'h0DFF, 8'h54},
        {16'hF000, 2'd3, 4'd5,  15'h0000, 8'h55},
        {16'hFE10, 2'd1, 4'd6,  15'h0010, 8'h76},
        {16'hFE10, 2'd2, 4'd15, 15'h0000, 8'hFF},
        {16'hFE9F, 2'd0, 4'd6,  15'h009F, 8'h05},
        {16'hFEA0, 2'd0, 4'd15, 15'h0000, 8'h00},
        {16'hFEFF, 2'd3, 4'd15, 15'h0000, 8'hFF},
        {16'hFF00, 2'd0, 4'd7,  15'h0000, 8'h77},
        {16'hFF7F, 2'd0, 4'd7,  15'h007F, 8'hF6},
        {16'hFF80, 2'd0, 4'd8,  15'h0000, 8'h88},
        {16'hFFFE, 2'd0, 4'd8,  15'h007E, 8'h06},
        {16'hFF50, 2'd0, 4'd15, 15'h0000, 8'hFF},
        {16'hDFFF, 2'd3, 4'd5,  15'h0FFF, 8'h54}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0]  cpu_rdata;
    logic [1:0]  disp_mode = 2'd0;
    logic [7:0]  line_count = '0;
    logic        coin_irq_en = 1'b0;
    logic [4:0]  irq_live = '0;
    logic [7:0]  mem_rdata;
    logic [8:0]  mem_sel;
    logic [14:0] mem_loc;
    logic        mem_we;
    logic [7:0]  line_cmp;
    logic        coin_flag, stat_irq_req, irq_push;
    logic [4:0]  irq_push_val, irq_enable;

    int n_run = 0, n_fail = 0;
    logic [8:0]  s_sel;
    logic [14:0] s_loc;
    logic        s_we;
    logic [7:0]  s_data;

    always #(CLK_NS/2) clk = ~clk;

    // Memory model: each region answers offset plus 0x11 times its index.
    always_comb begin
        mem_rdata = 8'h00;
        for (int i = 0; i < 9; i++)
            if (mem_sel[i]) mem_rdata = 8'(mem_loc[7:0] + 8'(8'h11 * i));
    end

    sysbus_decoder dut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic [15:0] a, input logic [1:0] m);
        @(negedge clk);
        cpu_addr = a; disp_mode = m; cpu_rd = 1'b1;
        #1; s_sel = mem_sel; s_loc = mem_loc;
        @(negedge clk);
        cpu_rd = 1'b0; s_data = cpu_rdata;
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d, input logic [1:0] m);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; disp_mode = m; cpu_wr = 1'b1;
        #1; s_sel = mem_sel; s_loc = mem_loc; s_we = mem_we;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 R12 reset state
        chk(cpu_rdata == 8'h00, "R11 reset rdata", cpu_rdata, 0);
        chk(mem_sel == '0, "R12 idle select", mem_sel, 0);
        chk(coin_flag == 1'b0, "R8 reset coin", coin_flag, 0);
        // R1 overlay on
        do_read(16'h00FF, 2'd0);
        chk(s_sel == 9'b1 && s_loc == 15'h00FF && s_data == 8'hFF, "R1 boot read", s_data, 8'hFF);
        do_read(16'h0100, 2'd0);
        chk(s_sel == 9'b10 && s_data == 8'h11, "R1 past overlay", s_data, 8'h11);
        do_write(16'h0010, 8'hAA, 2'd0);
        chk(s_sel == 9'b10 && s_we && s_loc == 15'h0010, "R1 write to cart", s_sel, 2);
        // R2 zero write keeps overlay
        do_write(16'hFF50, 8'h00, 2'd0);
        do_read(16'h0020, 2'd0);
        chk(s_sel == 9'b1, "R2 zero keeps overlay", s_sel, 1);
        do_write(16'hFF50, 8'h01, 2'd0);
        do_read(16'h0020, 2'd0);
        chk(s_sel == 9'b10 && s_data == 8'h31, "R2 overlay off", s_data, 8'h31);
        do_write(16'hFF50, 8'h00, 2'd0);
        do_read(16'h0020, 2'd0);
        chk(s_sel == 9'b10, "R2 stays off", s_sel, 2);
        // Table walk: R3 R4 R5 R6 R10 R11
        for (int v = 0; v < NV; v++) begin
            logic [3:0]  er;
            logic [14:0] el;
            logic [8:0]  es;
            er = VEC[v][26:23];
            el = VEC[v][22:8];
            es = (er == 4'd15) ? 9'd0 : 9'(1 << er);
            do_read(VEC[v][44:29], VEC[v][28:27]);
            chk(s_sel == es, $sformatf("R4 vec%0d select", v), s_sel, es);
            if (er != 4'd15)
                chk(s_loc == el, $sformatf("R10 vec%0d offset", v), s_loc, el);
            chk(s_data == VEC[v][7:0], $sformatf("R11 vec%0d data", v), s_data, VEC[v][7:0]);
        end
        // R3 R5 R6 dropped writes
        do_write(16'h9000, 8'h12, 2'd3);
        chk(s_sel == '0 && !s_we, "R3 draw write dropped", s_sel, 0);
        do_write(16'hFE00, 8'h12, 2'd2);
        chk(s_sel == '0 && !s_we, "R5 search write dropped", s_sel, 0);
        do_write(16'hFE00, 8'h12, 2'd0);
        chk(s_sel == 9'h040 && s_we, "R5 blank write", s_sel, 9'h040);
        do_write(16'hFEC0, 8'h12, 2'd1);
        chk(s_sel == '0 && !s_we, "R6 unusable write", s_sel, 0);
        do_write(16'hF123, 8'h12, 2'd3);
        chk(s_sel == 9'h020 && s_loc == 15'h0123 && s_we, "R4 mirror write", s_loc, 15'h0123);
        // R11 hold without read
        @(negedge clk); cpu_addr = 16'hC001;
        @(negedge clk);
        chk(cpu_rdata == s_data, "R11 hold", cpu_rdata, s_data);
        // R7 divider
        do_write(16'hFF04, 8'h5A, 2'd0);
        do_read(16'hFF04, 2'd0);
        chk(s_data == 8'h00, "R7 cleared", s_data, 0);
        repeat (300) @(negedge clk);
        do_read(16'hFF04, 2'd0);
        chk(s_data == 8'h01, "R7 upper byte", s_data, 1);
        // R8 line compare
        line_count = 8'h22; coin_irq_en = 1'b1;
        do_write(16'hFF45, 8'h22, 2'd0);
        #1;
        chk(coin_flag && stat_irq_req, "R8 match pulse", {coin_flag, stat_irq_req}, 3);
        @(negedge clk);
        chk(!stat_irq_req, "R8 single pulse", stat_irq_req, 0);
        do_read(16'hFF45, 2'd0);
        chk(s_data == 8'h22, "R8 read back", s_data, 8'h22);
        do_write(16'hFF45, 8'h23, 2'd0);
        #1;
        chk(!coin_flag && !stat_irq_req && line_cmp == 8'h23, "R8 mismatch", line_cmp, 8'h23);
        // R9 pending register
        irq_live = 5'b00001;
        @(negedge clk);
        cpu_addr = 16'hFF0F; cpu_wdata = 8'h08; cpu_wr = 1'b1;
        #1;
        chk(irq_push && irq_push_val == 5'h08, "R9 push", irq_push_val, 8);
        @(negedge clk); cpu_wr = 1'b0;
        do_read(16'hFF0F, 2'd0);
        chk(s_data == 8'h09, "R9 merged read", s_data, 8'h09);
        // R10 enable register
        do_write(16'hFFFF, 8'h1F, 2'd0);
        do_read(16'hFFFF, 2'd0);
        chk(s_data == 8'h1F && irq_enable == 5'h1F, "R10 enable reg", s_data, 8'h1F);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule